// File: doc/BRIEF.md
# Bfloat16 Multiply, FP32 Accumulate Cell

This block is one cell of a weight-stationary systolic matrix array. A bfloat16 weight is loaded into the cell through a push port and stays there until the next push. On every clock the cell multiplies the bfloat16 activation entering from its left by that weight, adds the product to the FP32 partial sum entering from above, and registers both results. The activation goes on to the right-hand neighbour and the new FP32 sum goes down to the cell below. Both hops take one cycle, so a square grid of these cells moves data one step per clock.

The multiply is exact. Two 8-bit significands give a 16-bit product, and that product always fits in an FP32 word without rounding. The only rounding step is the FP32 addition, which rounds to nearest with ties to even. Subnormal operands and subnormal results are replaced by a zero of the same sign. Special values follow a fixed and simple policy.

A cell in the bottom row also acts as the array's read-out point. When a pop is requested, the cell copies the sum it produces on that cycle into a holding register and flags it valid on the next cycle.

Top module: `bf16_mac_cell`

## Requirements
- R1: A bfloat16 value has 1 sign bit [15], an 8-bit exponent [14:7] with bias 127, and 7 fraction bits [6:0]. When both operands are normal, their product is converted to FP32 exactly: the sign is the XOR of the operand signs, the biased exponent is ea+eb-127 (plus 1 when the significand product is 2.0 or more), and all 16 bits of the significand product are kept.
- R2: The product is added to the FP32 partial sum (sign [31], exponent [30:23], fraction [22:0]) and the result is rounded to nearest, with ties going to the even significand.
- R3: Any bfloat16 or FP32 operand with an exponent field of zero counts as a zero of its own sign. Any result whose biased exponent would be 0 or less becomes a zero of the result's sign. An exact cancellation gives +0. The sum of two zeros has a negative sign only when both zeros are negative.
- R4: The cell outputs the canonical quiet NaN 0x7FC00000 in these cases: a NaN operand (exponent all ones, fraction non-zero), infinity times zero, and the sum of two infinities of any signs.
- R5: Infinity times a non-zero finite value gives an infinity whose sign is the XOR of the operand signs. Infinity plus a finite value keeps that infinity. A product or sum whose exponent exceeds 254 becomes an infinity of its own sign.
- R6: act_out equals act_in delayed by exactly one clock.
- R7: psum_out shows, one clock later, the rounded result computed from the act_in, psum_in and stored weight present at the preceding edge.
- R8: A weight presented with wt_push high is stored at that edge. It is used first by the multiply of the following cycle, never by the multiply in the cycle of the push. When wt_push is low the stored weight does not change, whatever wt_data carries.
- R9: When pop_rd is high at an edge, pop_data takes the sum produced at that same edge and pop_vld is high for the next cycle. When pop_rd is low, pop_data holds its value.
- R10: While rst_n is low, act_out, psum_out, pop_data and pop_vld are zero and the stored weight is +0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wt_push | input | 1 | Load wt_data as the new stationary weight |
| wt_data | input | 16 | bfloat16 weight to load |
| act_in | input | 16 | bfloat16 activation from the left neighbour |
| psum_in | input | 32 | FP32 partial sum from the cell above |
| pop_rd | input | 1 | Capture this cycle's sum for read-out |
| act_out | output | 16 | Registered activation to the right neighbour |
| psum_out | output | 32 | Registered FP32 sum to the cell below |
| pop_vld | output | 1 | pop_data was captured on the previous edge |
| pop_data | output | 32 | Captured FP32 sum |

## Verification
The bench targets rounding ties on both sides of the even rule at an exponent of 24. A design that rounds half away from zero, or that drops the sticky bits, returns a result one ULP off. It checks a product that uses all 16 significand bits; a cell that rounds the product to bfloat16 before adding loses the low byte. It drives subnormal inputs, products just above and just below the smallest normal, and a signed-zero sum, where a design without flushing leaks a subnormal word or gets the sign wrong. It also covers every special-value pairing in R4 and R5, and it pushes a weight in the same cycle as a multiply, where a cell that forwards the new weight too early computes with the wrong operand.

// File: rtl/mac_pkg.sv
`timescale 1ns/1ps
package mac_pkg;

  localparam int BF_W    = 16;
  localparam int FP_W    = 32;
  localparam int EXP_W   = 8;
  localparam int BF_FR_W = 7;
  localparam int FP_FR_W = 23;
  localparam int BIAS    = 127;
  localparam int EXP_MAX = (1 << EXP_W) - 1;
  localparam int SIG_W   = FP_FR_W + 1;
  localparam int ALN_W   = SIG_W + 3;
  localparam logic [FP_W-1:0] QNAN = 32'h7FC0_0000;

  // Exact bfloat16 x bfloat16 -> FP32, flush-to-zero, fixed special policy
  function automatic logic [FP_W-1:0] bf16_mul_exact(input logic [BF_W-1:0] a,
                                                      input logic [BF_W-1:0] b);
    logic s, a_nan, b_nan, a_inf, b_inf, a_z, b_z;
    logic [15:0] p;
    int e;
    s     = a[15] ^ b[15];
    a_z   = (a[14:7] == 8'd0);
    b_z   = (b[14:7] == 8'd0);
    a_nan = (a[14:7] == 8'hFF) && (a[6:0] != 7'd0);
    b_nan = (b[14:7] == 8'hFF) && (b[6:0] != 7'd0);
    a_inf = (a[14:7] == 8'hFF) && (a[6:0] == 7'd0);
    b_inf = (b[14:7] == 8'hFF) && (b[6:0] == 7'd0);
    if (a_nan || b_nan || (a_inf && b_z) || (b_inf && a_z)) return QNAN;
    if (a_inf || b_inf) return {s, 8'hFF, 23'd0};
    if (a_z || b_z) return {s, 31'd0};
    p = {8'd0, 1'b1, a[6:0]} * {8'd0, 1'b1, b[6:0]};
    e = int'(a[14:7]) + int'(b[14:7]) - BIAS + int'(p[15]);
    if (e >= EXP_MAX) return {s, 8'hFF, 23'd0};
    if (e <= 0) return {s, 31'd0};
    if (p[15]) return {s, 8'(e), p[14:0], 8'd0};
    return {s, 8'(e), p[13:0], 9'd0};
  endfunction

  // FP32 + FP32, round to nearest even, flush-to-zero
  function automatic logic [FP_W-1:0] fp32_add_rne(input logic [FP_W-1:0] a,
                                                    input logic [FP_W-1:0] b);
    logic sa, sb, a_z, b_z, a_nan, b_nan, a_inf, b_inf, sx, sub, stk, g, rs, inc;
    logic [7:0] ex, ey, d;
    logic [SIG_W-1:0] mx, my, mant;
    logic [ALN_W-1:0] ax, ay, yfull, n;
    logic [ALN_W:0] s;
    logic [SIG_W:0] mr;
    int p, er;
    sa    = a[31];
    sb    = b[31];
    a_z   = (a[30:23] == 8'd0);
    b_z   = (b[30:23] == 8'd0);
    a_nan = (a[30:23] == 8'hFF) && (a[22:0] != 23'd0);
    b_nan = (b[30:23] == 8'hFF) && (b[22:0] != 23'd0);
    a_inf = (a[30:23] == 8'hFF) && (a[22:0] == 23'd0);
    b_inf = (b[30:23] == 8'hFF) && (b[22:0] == 23'd0);
    if (a_nan || b_nan || (a_inf && b_inf)) return QNAN;
    if (a_inf) return {sa, 8'hFF, 23'd0};
    if (b_inf) return {sb, 8'hFF, 23'd0};
    if (a_z && b_z) return {sa & sb, 31'd0};
    if (a_z) return b;
    if (b_z) return a;
    sub = sa ^ sb;
    if (a[30:0] >= b[30:0]) begin
      sx = sa; ex = a[30:23]; ey = b[30:23];
      mx = {1'b1, a[22:0]}; my = {1'b1, b[22:0]};
    end else begin
      sx = sb; ex = b[30:23]; ey = a[30:23];
      mx = {1'b1, b[22:0]}; my = {1'b1, a[22:0]};
    end
    d     = ex - ey;
    yfull = {my, 3'b000};
    ax    = {mx, 3'b000};
    if (d >= 8'(ALN_W)) begin
      ay = {{(ALN_W-1){1'b0}}, 1'b1};
    end else begin
      stk = |(yfull & ((27'd1 << d) - 27'd1));
      ay  = (yfull >> d) | {{(ALN_W-1){1'b0}}, stk};
    end
    s = sub ? ({1'b0, ax} - {1'b0, ay}) : ({1'b0, ax} + {1'b0, ay});
    if (s == '0) return 32'd0;
    p = 0;
    for (int i = 0; i <= ALN_W; i++) if (s[i]) p = i;
    if (p == ALN_W) begin
      n  = {s[ALN_W:2], s[1] | s[0]};
      er = int'(ex) + 1;
    end else begin
      n  = s[ALN_W-1:0] << (ALN_W - 1 - p);
      er = int'(ex) - (ALN_W - 1 - p);
    end
    mant = n[ALN_W-1:3];
    g    = n[2];
    rs   = n[1] | n[0];
    inc  = g & (rs | mant[0]);
    mr   = {1'b0, mant} + {{SIG_W{1'b0}}, inc};
    if (mr[SIG_W]) begin
      mr = mr >> 1;
      er = er + 1;
    end
    if (er >= EXP_MAX) return {sx, 8'hFF, 23'd0};
    if (er <= 0) return {sx, 31'd0};
    return {sx, 8'(er), mr[22:0]};
  endfunction

endpackage

// File: rtl/bf16_exact_mul.sv
`timescale 1ns/1ps
module bf16_exact_mul
  import mac_pkg::*;
(
  input  logic [BF_W-1:0] a_i,
  input  logic [BF_W-1:0] b_i,
  output logic [FP_W-1:0] prod_o,
  output logic            nan_o,
  output logic            inf_o
);
  assign prod_o = bf16_mul_exact(a_i, b_i);
  assign nan_o  = (prod_o == QNAN);
  assign inf_o  = (prod_o[30:23] == 8'hFF) && (prod_o[22:0] == 23'd0);

  always_comb begin
    // R3: product never carries a subnormal encoding
    p_mul_ftz_r3: assert (prod_o[30:23] != 8'd0 || prod_o[22:0] == 23'd0);
    // R1: a product of two normal finite operands takes the XOR sign
    if (a_i[14:7] != 8'd0 && a_i[14:7] != 8'hFF && b_i[14:7] != 8'd0 && b_i[14:7] != 8'hFF)
      p_mul_sign_r1: assert (prod_o[31] == (a_i[15] ^ b_i[15]));
  end
endmodule

// File: rtl/fp32_rne_add.sv
`timescale 1ns/1ps
module fp32_rne_add
  import mac_pkg::*;
(
  input  logic [FP_W-1:0] a_i,
  input  logic [FP_W-1:0] b_i,
  output logic [FP_W-1:0] sum_o,
  output logic            nan_o,
  output logic            inf_o
);
  assign sum_o = fp32_add_rne(a_i, b_i);
  assign nan_o = (sum_o[30:23] == 8'hFF) && (sum_o[22:0] != 23'd0);
  assign inf_o = (sum_o[30:23] == 8'hFF) && (sum_o[22:0] == 23'd0);

  always_comb begin
    // R3: no subnormal sum leaves the adder
    p_add_ftz_r3: assert (sum_o[30:23] != 8'd0 || sum_o[22:0] == 23'd0);
    // R4: every NaN leaving the adder is the canonical one
    if (nan_o) p_add_qnan_r4: assert (sum_o == QNAN);
  end
endmodule

// File: rtl/bf16_mac_cell.sv
`timescale 1ns/1ps
module bf16_mac_cell
  import mac_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wt_push,
  input  logic [15:0] wt_data,
  input  logic [15:0] act_in,
  input  logic [31:0] psum_in,
  input  logic        pop_rd,
  output logic [15:0] act_out,
  output logic [31:0] psum_out,
  output logic        pop_vld,
  output logic [31:0] pop_data
);
  logic [BF_W-1:0] wt_q, act_q;
  logic [FP_W-1:0] sum_q, pop_q, prod, sum_d;
  logic            vld_q, mul_nan, mul_inf, add_nan, add_inf;
  logic            psum_is_nan;

  bf16_exact_mul u_mul (
    .a_i(act_in), .b_i(wt_q), .prod_o(prod), .nan_o(mul_nan), .inf_o(mul_inf)
  );

  fp32_rne_add u_add (
    .a_i(prod), .b_i(psum_in), .sum_o(sum_d), .nan_o(add_nan), .inf_o(add_inf)
  );

  assign psum_is_nan = (psum_in[30:23] == 8'hFF) && (psum_in[22:0] != 23'd0);

  // stationary weight: new value only seen by the next cycle's multiply
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wt_q <= '0;
    else if (wt_push) wt_q <= wt_data;
  end

  // systolic hop registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
      sum_q <= '0;
    end else begin
      act_q <= act_in;
      sum_q <= sum_d;
    end
  end

  // read-out capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pop_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= pop_rd;
      if (pop_rd) pop_q <= sum_d;
    end
  end

  assign act_out  = act_q;
  assign psum_out = sum_q;
  assign pop_vld  = vld_q;
  assign pop_data = pop_q;

  p_act_hop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> act_out == $past(act_in));
  p_sum_hop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> psum_out == $past(sum_d));
  p_wt_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wt_push |=> wt_q == $past(wt_data));
  p_wt_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wt_push |=> $stable(wt_q));
  p_pop_vld_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pop_rd |=> pop_vld);
  p_pop_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !pop_rd |=> $stable(pop_data));
  p_pop_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pop_vld |-> pop_data == psum_out);
  p_nan_in_r4: assert property (@(posedge clk) disable iff (!rst_n)
    psum_is_nan |=> psum_out == QNAN);
  p_nan_prop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mul_nan |-> add_nan);
  p_inf_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mul_inf && psum_in[30:23] != 8'hFF) |-> add_inf);
endmodule

// File: tb/sim_bf16_mac_cell.sv
`timescale 1ns/1ps
module sim_bf16_mac_cell;
  logic        clk = 1'b0;
  logic        rst_n, wt_push, pop_rd, pop_vld;
  logic [15:0] wt_data, act_in, act_out;
  logic [31:0] psum_in, psum_out, pop_data;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bf16_mac_cell u0 (
    .clk(clk), .rst_n(rst_n), .wt_push(wt_push), .wt_data(wt_data),
    .act_in(act_in), .psum_in(psum_in), .pop_rd(pop_rd),
    .act_out(act_out), .psum_out(psum_out), .pop_vld(pop_vld), .pop_data(pop_data)
  );

  // {req, act, weight, psum, expected}
  localparam int NV = 18;
  localparam logic [99:0] VEC [NV] = '{
    {4'd1,  16'h3FC0, 16'h3FC0, 32'h0000_0000, 32'h4010_0000}, // R1 1.5*1.5
    {4'd1,  16'h3FFF, 16'h3FFF, 32'h0000_0000, 32'h407E_0100}, // R1 full 16-bit product
    {4'd1,  16'h2000, 16'h2000, 32'h0000_0000, 32'h0080_0000}, // R1 smallest normal
    {4'd2,  16'h4000, 16'h4040, 32'h3F80_0000, 32'h40E0_0000}, // R2 6+1
    {4'd2,  16'h3F80, 16'h3F80, 32'h4B80_0000, 32'h4B80_0000}, // R2 tie stays even
    {4'd2,  16'h4040, 16'h3F80, 32'h4B80_0000, 32'h4B80_0002}, // R2 tie rounds up to even
    {4'd2,  16'h3FC0, 16'h3F80, 32'h4B80_0000, 32'h4B80_0001}, // R2 above half
    {4'd2,  16'h3F80, 16'h3F80, 32'h4E80_0000, 32'h4E80_0000}, // R2 sticky only
    {4'd2,  16'hBFC0, 16'h4000, 32'h3F80_0000, 32'hC000_0000}, // R2 negative result
    {4'd3,  16'hBF80, 16'h3FC0, 32'h3FC0_0000, 32'h0000_0000}, // R3 exact cancel +0
    {4'd3,  16'h0040, 16'h4000, 32'h3F80_0000, 32'h3F80_0000}, // R3 subnormal act
    {4'd3,  16'h0000, 16'h3F80, 32'h0040_0000, 32'h0000_0000}, // R3 subnormal psum
    {4'd3,  16'h9C80, 16'h1C80, 32'h8000_0000, 32'h8000_0000}, // R3 underflow, -0 + -0
    {4'd3,  16'h1F80, 16'h2000, 32'h0000_0000, 32'h0000_0000}, // R3 just below normal
    {4'd4,  16'h7FC1, 16'h3F80, 32'h3F80_0000, 32'h7FC0_0000}, // R4 NaN act
    {4'd4,  16'h7F80, 16'h0000, 32'h3F80_0000, 32'h7FC0_0000}, // R4 inf*0
    {4'd4,  16'h7F80, 16'h3F80, 32'hFF80_0000, 32'h7FC0_0000}, // R4 inf + -inf
    {4'd5,  16'h7180, 16'h7180, 32'h3F80_0000, 32'h7F80_0000}  // R5 product overflow
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wt_push = 1'b1; wt_data = 16'h4000;
    act_in = 16'h3F80; psum_in = 32'h3F80_0000; pop_rd = 1'b1;
    repeat (3) tick();
    chk("R10 act_out", {16'd0, act_out}, 32'd0);
    chk("R10 psum_out", psum_out, 32'd0);
    chk("R10 pop_data", pop_data, 32'd0);
    chk("R10 pop_vld", {31'd0, pop_vld}, 32'd0);
    rst_n = 1'b1; wt_push = 1'b0; pop_rd = 1'b0;
    tick();
    chk("R10 weight is +0", psum_out, 32'h3F80_0000);

    for (int i = 0; i < NV; i++) begin
      wt_push = 1'b1; wt_data = VEC[i][79:64];
      tick();
      wt_push = 1'b0;
      act_in = VEC[i][95:80]; psum_in = VEC[i][63:32];
      tick();
      chk($sformatf("R%0d vec %0d", VEC[i][99:96], i), psum_out, VEC[i][31:0]);
      chk($sformatf("R6 vec %0d", i), {16'd0, act_out}, {16'd0, VEC[i][95:80]});
    end

    // R5 infinity times finite, plus finite
    wt_push = 1'b1; wt_data = 16'h3F80; tick();
    wt_push = 1'b0; act_in = 16'hFF80; psum_in = 32'h4000_0000; tick();
    chk("R5 -inf plus finite", psum_out, 32'hFF80_0000);

    // R8 push in the same cycle as a multiply uses the old weight
    wt_push = 1'b1; wt_data = 16'h4000; act_in = 16'h3F80; psum_in = 32'd0; tick();
    chk("R8 old weight during push", psum_out, 32'h3F80_0000);
    wt_push = 1'b0; wt_data = 16'h4040; tick();
    chk("R8 new weight next cycle", psum_out, 32'h4000_0000);
    chk("R7 sum one cycle after", psum_out, 32'h4000_0000);
    tick();
    chk("R8 wt_data ignored without push", psum_out, 32'h4000_0000);

    // R9 pop capture and hold
    pop_rd = 1'b1; act_in = 16'h4040; tick();
    chk("R9 pop_data", pop_data, 32'h40C0_0000);
    chk("R9 pop_vld high", {31'd0, pop_vld}, 32'd1);
    pop_rd = 1'b0; act_in = 16'h3F80; tick();
    chk("R9 pop_data held", pop_data, 32'h40C0_0000);
    chk("R9 pop_vld low", {31'd0, pop_vld}, 32'd0);
    chk("R7 sum moves on", psum_out, 32'h4000_0000);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule